// File: doc/BRIEF.md
# Video Input Bus Formatter

This block sits at the front of a video output path. It takes three 10-bit input buses (S, Y and C), samples them on every rising edge of the pixel clock, and produces one pixel stream of three 10-bit components with a valid strobe. The components are Y, Cb and Cr, or G, B and R. Horizontal and vertical sync come from dedicated input pins. They leave the block delayed so that they stay lined up with the data in whichever format is active. Embedded timing codes in the data are never interpreted.

Four static configuration inputs steer the mapping from buses to components:
- an RGB enable, which selects 4:4:4 on all three buses;
- a dual-bus select, which chooses between 4:2:2 on one bus and 4:2:2 with luma and chroma on separate buses;
- a width select, for 8 or 10 bits;
- a bus-swap bit, which moves the 4:2:2 sources one bus along.

A 3-bit input-mode field is accepted, but only the standard-definition configuration exists, so every code behaves as code 000.

The output is a plain stream with no back-pressure. The source is a free-running video interface that cannot be stalled, so there is no ready input. A downstream consumer must take every pixel on the clock in which `out_valid` is high. The output components hold their last value while `out_valid` is low.

Top module: `vid_bus_fmt`

## Requirements
- R1: While reset is asserted, and until the first pixel is emitted, `out_valid` is 0 and the components read 0. The sync outputs are also 0 during reset and until sync input values sampled after reset reach them.
- R2: In single-bus 4:2:2 (RGB enable 0, dual select 0), samples are taken from the S bus when swap is 0 and from the Y bus when swap is 1; the other buses have no effect on the output.
- R3: In single-bus 4:2:2 the sample order from a line start is Cb, Y, Cr, Y. Each luma sample leaves as one pixel carrying the Cb and Cr of its own pair. That pixel appears on the second rising edge after the edge that sampled the luma. `out_valid` is therefore never high on two consecutive clocks.
- R4: In dual-bus 4:2:2 (RGB enable 0, dual select 1), luma is on S and chroma on Y when swap is 0, and on Y and C when swap is 1. Chroma is Cb on even-phase samples and Cr on odd-phase samples. Each luma leaves with its pair's chroma on the first rising edge after its sampling edge.
- R5: With RGB enable 1, R is taken from S, G from Y and B from C. The pixel appears on `out_crr`, `out_yg` and `out_cbb` at the edge that samples it, with `out_valid` high every clock. RGB enable overrides the dual select, and swap has no effect.
- R6: With width select 0 (8-bit), output bits [9:2] come from bus bits [9:2], and output bits [1:0] are zero.
- R7: `out_hsync` and `out_vsync` are updated on the same edge as a luma sample taken together with them. They show the sync inputs sampled 0 edges earlier in RGB, 1 in dual-bus and 2 in single-bus mode.
- R8: A sample in which `hsync_in` is high while it was low at the previous sample is phase 0 (Cb), whatever the phase count was.
- R9: Every value of `cfg_mode` gives the same output as 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 3 | Input-mode code; all values act as standard definition |
| cfg_rgb | input | 1 | 1: 4:4:4 RGB on all three buses |
| cfg_dual | input | 1 | 4:2:2 layout: 0 single bus, 1 luma and chroma on separate buses |
| cfg_wide | input | 1 | 1: 10-bit buses, 0: 8-bit on bits [9:2] |
| cfg_swap | input | 1 | Moves the 4:2:2 sources one bus along |
| bus_s | input | 10 | S input bus |
| bus_y | input | 10 | Y input bus |
| bus_c | input | 10 | C input bus |
| hsync_in | input | 1 | Horizontal sync, active high |
| vsync_in | input | 1 | Vertical sync, active high |
| out_valid | output | 1 | Pixel strobe, one pixel per high clock |
| out_yg | output | 10 | Luma, or green |
| out_cbb | output | 10 | Cb, or blue |
| out_crr | output | 10 | Cr, or red |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |

## Verification
A pixel is due on the edge that samples it in RGB mode, one edge after its luma sample in dual-bus mode, and two edges after it in single-bus mode. The sync outputs follow the same per-mode offsets. The driver counts rising edges and stamps every expected pixel with the edge at which it must appear. The monitor samples on falling edges and compares that stamp as well as the component values, and it flags any pixel nobody expected. The sync outputs are compared every clock against a bench-side history of the sync inputs, indexed by the mode recorded at that edge.

// File: rtl/vbf_pkg.sv
package vbf_pkg;

  typedef enum logic [1:0] {
    FMT_SINGLE = 2'd0,
    FMT_DUAL   = 2'd1,
    FMT_RGB    = 2'd2
  } fmt_e;

  // RGB enable wins over the 4:2:2 layout select
  function automatic fmt_e fmt_pick(input logic rgb_en, input logic dual_en);
    if (rgb_en)       return FMT_RGB;
    else if (dual_en) return FMT_DUAL;
    else              return FMT_SINGLE;
  endfunction

endpackage

// File: rtl/vbf_bus_sel.sv
module vbf_bus_sel
  import vbf_pkg::*;
#(
  parameter int W      = 10,
  parameter int NARROW = 8
) (
  input  fmt_e         fmt,
  input  logic         wide,
  input  logic         swap,
  input  logic [W-1:0] bus_s,
  input  logic [W-1:0] bus_y,
  input  logic [W-1:0] bus_c,
  output logic [W-1:0] lane_a,
  output logic [W-1:0] lane_b,
  output logic [W-1:0] lane_c
);
  localparam int PAD = W - NARROW;
  localparam logic [W-1:0] MASK_NARROW = {{NARROW{1'b1}}, {PAD{1'b0}}};

  logic [W-1:0] mask;
  logic [W-1:0] raw_a, raw_b, raw_c;

  assign mask = wide ? {W{1'b1}} : MASK_NARROW;

  always_comb begin
    if (fmt == FMT_RGB) begin
      raw_a = bus_y;              // green
      raw_b = bus_c;              // blue
      raw_c = bus_s;              // red
    end else begin
      raw_a = swap ? bus_y : bus_s;   // luma or interleaved stream
      raw_b = swap ? bus_c : bus_y;   // chroma in dual-bus layout
      raw_c = bus_s;
    end
  end

  assign lane_a = raw_a & mask;
  assign lane_b = raw_b & mask;
  assign lane_c = raw_c & mask;

endmodule

// File: rtl/vbf_phase.sv
module vbf_phase #(
  parameter int PH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hsync_in,
  output logic [PH_W-1:0] phase
);
  logic [PH_W-1:0] cnt;
  logic            hs_prev;
  logic            hs_rise;

  assign hs_rise = hsync_in & ~hs_prev;
  assign phase   = hs_rise ? '0 : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      hs_prev <= 1'b0;
    end else begin
      cnt     <= phase + 1'b1;
      hs_prev <= hsync_in;
    end
  end

endmodule

// File: rtl/vbf_sync_dly.sv
module vbf_sync_dly #(
  parameter int DEPTH = 3,
  parameter int NSIG  = 2,
  localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSIG-1:0]  sync_in,
  input  logic [SEL_W-1:0] sel,
  output logic [NSIG-1:0]  sync_out
);
  logic [NSIG-1:0] tap [DEPTH];

  assign tap[0] = sync_in;

  genvar i;
  generate
    for (i = 1; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap[i] <= '0;
        else        tap[i] <= tap[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_out <= '0;
    else        sync_out <= tap[sel];
  end

endmodule

// File: rtl/vbf_assemble.sv
module vbf_assemble
  import vbf_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  fmt_e         fmt,
  input  logic [1:0]   phase,
  input  logic [W-1:0] lane_a,
  input  logic [W-1:0] lane_b,
  input  logic [W-1:0] lane_c,
  output logic         out_valid,
  output logic [W-1:0] out_yg,
  output logic [W-1:0] out_cbb,
  output logic [W-1:0] out_crr
);
  logic [W-1:0] y_a, y_b, cb_w, cr_w, cb_h, cr_h;
  logic         pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_yg    <= '0;
      out_cbb   <= '0;
      out_crr   <= '0;
      y_a       <= '0;
      y_b       <= '0;
      cb_w      <= '0;
      cr_w      <= '0;
      cb_h      <= '0;
      cr_h      <= '0;
      pend      <= 1'b0;
    end else begin
      unique case (fmt)
        FMT_RGB: begin
          out_valid <= 1'b1;
          out_yg    <= lane_a;
          out_cbb   <= lane_b;
          out_crr   <= lane_c;
          pend      <= 1'b0;
        end
        FMT_DUAL: begin
          if (!phase[0]) begin
            y_a       <= lane_a;
            cb_w      <= lane_b;
            out_valid <= pend;
            pend      <= 1'b0;
            if (pend) begin
              out_yg  <= y_b;
              out_cbb <= cb_h;
              out_crr <= cr_h;
            end
          end else begin
            out_valid <= 1'b1;
            out_yg    <= y_a;
            out_cbb   <= cb_w;
            out_crr   <= lane_b;
            y_b       <= lane_a;
            cb_h      <= cb_w;
            cr_h      <= lane_b;
            pend      <= 1'b1;
          end
        end
        default: begin
          unique case (phase)
            2'd0: begin
              cb_w      <= lane_a;
              out_valid <= 1'b0;
            end
            2'd1: begin
              y_a       <= lane_a;
              out_valid <= pend;
              pend      <= 1'b0;
              if (pend) begin
                out_yg  <= y_b;
                out_cbb <= cb_h;
                out_crr <= cr_h;
              end
            end
            2'd2: begin
              cr_w      <= lane_a;
              out_valid <= 1'b0;
            end
            default: begin
              out_valid <= 1'b1;
              out_yg    <= y_a;
              out_cbb   <= cb_w;
              out_crr   <= cr_w;
              y_b       <= lane_a;
              cb_h      <= cb_w;
              cr_h      <= cr_w;
              pend      <= 1'b1;
            end
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/vid_bus_fmt.sv
module vid_bus_fmt
  import vbf_pkg::*;
#(
  parameter int W      = 10,
  parameter int NARROW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   cfg_mode,
  input  logic         cfg_rgb,
  input  logic         cfg_dual,
  input  logic         cfg_wide,
  input  logic         cfg_swap,
  input  logic [W-1:0] bus_s,
  input  logic [W-1:0] bus_y,
  input  logic [W-1:0] bus_c,
  input  logic         hsync_in,
  input  logic         vsync_in,
  output logic         out_valid,
  output logic [W-1:0] out_yg,
  output logic [W-1:0] out_cbb,
  output logic [W-1:0] out_crr,
  output logic         out_hsync,
  output logic         out_vsync
);
  localparam int SYNC_DEPTH = 3;
  localparam int SEL_W      = $clog2(SYNC_DEPTH);
  localparam logic [SEL_W-1:0] TAP_RGB    = SEL_W'(0);
  localparam logic [SEL_W-1:0] TAP_DUAL   = SEL_W'(1);
  localparam logic [SEL_W-1:0] TAP_SINGLE = SEL_W'(2);

  // only the standard-definition configuration exists
  logic unused_mode_bits;
  assign unused_mode_bits = ^cfg_mode;

  fmt_e             fmt;
  logic [1:0]       phase;
  logic [W-1:0]     lane_a, lane_b, lane_c;
  logic [SEL_W-1:0] tap_sel;

  assign fmt = fmt_pick(cfg_rgb, cfg_dual);

  always_comb begin
    unique case (fmt)
      FMT_RGB:  tap_sel = TAP_RGB;
      FMT_DUAL: tap_sel = TAP_DUAL;
      default:  tap_sel = TAP_SINGLE;
    endcase
  end

  vbf_bus_sel #(.W(W), .NARROW(NARROW)) i_sel (
    .fmt    (fmt),
    .wide   (cfg_wide),
    .swap   (cfg_swap),
    .bus_s  (bus_s),
    .bus_y  (bus_y),
    .bus_c  (bus_c),
    .lane_a (lane_a),
    .lane_b (lane_b),
    .lane_c (lane_c)
  );

  vbf_phase #(.PH_W(2)) i_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .hsync_in (hsync_in),
    .phase    (phase)
  );

  vbf_assemble #(.W(W)) i_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt       (fmt),
    .phase     (phase),
    .lane_a    (lane_a),
    .lane_b    (lane_b),
    .lane_c    (lane_c),
    .out_valid (out_valid),
    .out_yg    (out_yg),
    .out_cbb   (out_cbb),
    .out_crr   (out_crr)
  );

  vbf_sync_dly #(.DEPTH(SYNC_DEPTH), .NSIG(2)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_in  ({hsync_in, vsync_in}),
    .sel      (tap_sel),
    .sync_out ({out_hsync, out_vsync})
  );

endmodule

// File: rtl/vbf_chk.sv
module vbf_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   cfg_mode,
  input logic         cfg_rgb,
  input logic         cfg_dual,
  input logic         cfg_wide,
  input logic         cfg_swap,
  input logic [W-1:0] bus_s,
  input logic [W-1:0] bus_y,
  input logic [W-1:0] bus_c,
  input logic         hsync_in,
  input logic         vsync_in,
  input logic         out_valid,
  input logic [W-1:0] out_yg,
  input logic [W-1:0] out_cbb,
  input logic [W-1:0] out_crr,
  input logic         out_hsync,
  input logic         out_vsync
);
  logic [2:0] seen;
  logic       is_single, is_dual;

  assign is_single = !cfg_rgb && !cfg_dual;
  assign is_dual   = !cfg_rgb && cfg_dual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           seen <= '0;
    else if (seen != 3'd7) seen <= seen + 1'b1;
  end

  AST_RGB_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd1 && $past(cfg_rgb)) |-> out_valid); // R5

  AST_RGB_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd1 && $past(cfg_rgb) && $past(cfg_wide)) |->
    (out_crr == $past(bus_s) && out_yg == $past(bus_y) && out_cbb == $past(bus_c))); // R5

  AST_NARROW_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd4 && out_valid && !$past(cfg_wide) && !$past(cfg_wide, 2) &&
     !$past(cfg_wide, 3) && !$past(cfg_wide, 4)) |->
    (out_yg[1:0] == 2'b00 && out_cbb[1:0] == 2'b00 && out_crr[1:0] == 2'b00)); // R6

  AST_SINGLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd1 && is_single && $past(is_single) && out_valid) |=> !out_valid); // R3

  AST_HS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd1 && is_single && $rose(hsync_in)) |=> !out_valid); // R8

  AST_SYNC_RGB: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd3 && $past(cfg_rgb)) |->
    (out_hsync == $past(hsync_in) && out_vsync == $past(vsync_in))); // R7

  AST_SYNC_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd3 && $past(is_dual)) |->
    (out_hsync == $past(hsync_in, 2) && out_vsync == $past(vsync_in, 2))); // R7

  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd3 && $past(is_single)) |->
    (out_hsync == $past(hsync_in, 3) && out_vsync == $past(vsync_in, 3))); // R7

  logic unused_chk;
  assign unused_chk = ^{cfg_mode, cfg_swap};

endmodule

bind vid_bus_fmt vbf_chk #(.W(W)) i_chk (.*);

// File: tb/test_vid_bus_fmt.sv
module test_vid_bus_fmt;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   cfg_mode = '0;
  logic         cfg_rgb = 1'b0, cfg_dual = 1'b0, cfg_wide = 1'b1, cfg_swap = 1'b0;
  logic [W-1:0] bus_s = '0, bus_y = '0, bus_c = '0;
  logic         hsync_in = 1'b0, vsync_in = 1'b0;
  logic         out_valid, out_hsync, out_vsync;
  logic [W-1:0] out_yg, out_cbb, out_crr;

  always #10 clk = ~clk;

  vid_bus_fmt i_vid_bus_fmt (.*);

  typedef struct {
    logic [W-1:0] yg, cb, cr;
    int           due;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0, cyc = 0;

  // configuration applied together with the next sample
  logic [2:0] p_mode = '0;
  logic       p_rgb = 0, p_dual = 0, p_wide = 1, p_swap = 0;

  // bench-side sync history and per-edge sync offset
  logic [1:0] h1 = '0, h2 = '0, h3 = '0;
  int         d_at = 2;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic logic [W-1:0] r10();
    return W'($urandom % 1024);
  endfunction

  function automatic logic [W-1:0] msk(input logic [W-1:0] v);
    return p_wide ? v : {v[W-1:2], 2'b00};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      h1 <= '0; h2 <= '0; h3 <= '0;
    end else begin
      h1 <= {hsync_in, vsync_in};
      h2 <= h1;
      h3 <= h2;
    end
    d_at <= cfg_rgb ? 0 : (cfg_dual ? 1 : 2);
  end

  // monitor: pops expected pixels, checks sync every clock
  always @(negedge clk) begin
    if (rst_n) begin
      logic [1:0] es;
      es = (d_at == 0) ? h1 : ((d_at == 1) ? h2 : h3);
      check({out_hsync, out_vsync} == es, "R7", "sync offset",
            {out_hsync, out_vsync}, es);
      if (out_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R3", "unexpected pixel", out_yg, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(out_yg == e.yg && out_cbb == e.cb && out_crr == e.cr && cyc == e.due,
                e.tag, $sformatf("pixel yg/cb/cr/edge %0d/%0d/%0d/%0d vs", out_yg, out_cbb, out_crr, cyc),
                out_yg, e.yg);
          if (!(out_yg == e.yg && out_cbb == e.cb && out_crr == e.cr && cyc == e.due))
            $display("  expected yg/cb/cr/edge %0d/%0d/%0d/%0d", e.yg, e.cb, e.cr, e.due);
        end
      end
    end
  end

  task automatic drive(input logic [W-1:0] s, y, c, input logic hs, input bit chk8);
    @(negedge clk);
    if (chk8) check(out_valid == 1'b0, "R8", "valid after line restart", out_valid, 0);
    cfg_mode = p_mode; cfg_rgb = p_rgb; cfg_dual = p_dual;
    cfg_wide = p_wide; cfg_swap = p_swap;
    bus_s = s; bus_y = y; bus_c = c;
    hsync_in = hs;
    vsync_in = 1'($urandom % 2);
  endtask

  task automatic push(input logic [W-1:0] yg, cb, cr, input string tag);
    exp_t e;
    e.yg = msk(yg); e.cb = msk(cb); e.cr = msk(cr);
    e.due = cyc + 1; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drv1(input logic [W-1:0] v, input logic hs, input bit chk8);
    if (p_swap) drive(r10(), v, r10(), hs, chk8);
    else        drive(v, r10(), r10(), hs, chk8);
  endtask

  task automatic drv2(input logic [W-1:0] l, k, input logic hs);
    if (p_swap) drive(r10(), l, k, hs, 1'b0);
    else        drive(l, k, r10(), hs, 1'b0);
  endtask

  task automatic run_single(input int n, input string tag, input bit chk8);
    logic [W-1:0] pcb = '0, pcr = '0, py1 = '0;
    for (int j = 0; j < n; j++) begin
      logic [W-1:0] cb, y0, cr, y1;
      cb = r10(); y0 = r10(); cr = r10(); y1 = r10();
      drv1(cb, j == 0, 1'b0);
      drv1(y0, 1'b0, chk8 && j == 0);
      if (j > 0) push(py1, pcb, pcr, tag);
      drv1(cr, 1'b0, 1'b0);
      drv1(y1, 1'b0, 1'b0);
      push(y0, cb, cr, tag);
      pcb = cb; pcr = cr; py1 = y1;
    end
    drv1(r10(), 1'b0, 1'b0);
    drv1(r10(), 1'b0, 1'b0);
    push(py1, pcb, pcr, tag);
  endtask

  task automatic run_dual(input int n, input string tag);
    logic [W-1:0] pcb = '0, pcr = '0, py1 = '0;
    for (int j = 0; j < n; j++) begin
      logic [W-1:0] cb, y0, cr, y1;
      cb = r10(); y0 = r10(); cr = r10(); y1 = r10();
      drv2(y0, cb, j == 0);
      if (j > 0) push(py1, pcb, pcr, tag);
      drv2(y1, cr, 1'b0);
      push(y0, cb, cr, tag);
      pcb = cb; pcr = cr; py1 = y1;
    end
    drv2(r10(), r10(), 1'b0);
    push(py1, pcb, pcr, tag);
  endtask

  task automatic run_rgb(input int n, input string tag);
    for (int j = 0; j < n; j++) begin
      logic [W-1:0] s, y, c;
      s = r10(); y = r10(); c = r10();
      drive(s, y, c, j == 0, 1'b0);
      push(y, c, s, tag);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    check(1'b0, "R3", "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      bus_s = r10(); bus_y = r10(); bus_c = r10();
      check(out_valid == 1'b0 && out_yg == '0 && out_cbb == '0 && out_crr == '0,
            "R1", "outputs in reset", out_valid, 0);
      check({out_hsync, out_vsync} == 2'b00, "R1", "sync in reset",
            {out_hsync, out_vsync}, 0);
    end
    rst_n = 1'b1;

    run_single(3, "R2", 1'b0);          // S bus
    p_swap = 1; run_single(3, "R2", 1'b0);  // Y bus
    p_swap = 0; run_single(2, "R3", 1'b0);
    p_wide = 0; run_single(2, "R6", 1'b0);
    p_wide = 1;
    drv1(r10(), 1'b0, 1'b0);            // leaves the count at phase 2
    run_single(2, "R8", 1'b1);
    p_mode = 3'b101; run_single(2, "R9", 1'b0);
    p_mode = 3'b000;

    p_dual = 1; run_dual(4, "R4");
    p_swap = 1; run_dual(3, "R4");
    p_swap = 0; p_wide = 0; run_dual(2, "R6");
    p_wide = 1; p_mode = 3'b011; run_dual(2, "R9");
    p_mode = 3'b000;

    p_rgb = 1; p_dual = 0; run_rgb(6, "R5");
    p_swap = 1; run_rgb(3, "R5");       // swap has no effect
    p_swap = 0; p_wide = 0; run_rgb(3, "R6");
    p_wide = 1; p_dual = 1; run_rgb(3, "R5");  // RGB overrides dual

    p_rgb = 0; p_dual = 0;
    drv1(r10(), 1'b1, 1'b0);
    drv1(r10(), 1'b0, 1'b0);
    @(negedge clk);
    check(q.size() == 0, "R4", "pixels still expected", q.size(), 0);
    summary();
    $finish;
  end

endmodule